// File: doc/BRIEF.md
# Footprint Writeback Queue for Page Table Entries

When a translation entry is evicted, the cache hierarchy still has to save two small per-page vectors. One is a reference vector that records which sub-blocks of the page were touched. The other is a valid vector that records which sub-blocks are currently filled. This block holds those save commands in a short queue, so the eviction path only pays for one enqueue. In the background it drains the queue into the page table. For each command it reads the 64-bit entry, inserts the vectors into the spare upper bits and writes the entry back, leaving the translation bits as they were.

Reference vectors for the same page can arrive from several sources. Disagreement between them is harmless because the block combines them with a bitwise OR, both against the stored value and against a command still waiting in the queue. The valid vector always takes the most recent value. An all-zero valid vector is how a page eviction clears the stored field. A command for an address that is already waiting merges into that slot instead of taking a new one. Commands for different addresses drain in arrival order. A `drained` flag lets the surrounding logic wait until everything has reached the table.

Top module: `fpWbQueue`

## Requirements
- R1: After reset, `drained` and `pushReady` are 1 and neither `memRdEn` nor `memWrEn` is asserted.
- R2: A writeback leaves bits [47:0] of the entry exactly as read. It places the reference result in bits [63:56] and the valid result in bits [55:48].
- R3: The reference result is the bitwise OR of the stored reference field and every reference vector accepted for that address since its previous writeback.
- R4: The valid result is the valid vector of the most recently accepted command for that address. An all-zero vector clears the field.
- R5: Commands for distinct addresses are written to the page table in the order they were accepted.
- R6: A command whose address matches a command still waiting in the queue (not yet taken for writeback) merges into it. No extra slot and no extra table write result.
- R7: With all DEPTH slots holding distinct addresses, `pushReady` is 0 for a new address. A command offered while `pushReady` is 0 is ignored and changes no table entry.
- R8: Each writeback is a read with `memRdEn` in one cycle, then a write with `memWrEn` to the same `memAddr` in the next cycle, using `memRdData` returned one cycle after the read.
- R9: `drained` is 0 from the cycle after a command is accepted until its table write has been issued. While `drained` is 1, no memory strobe is active.
- R10: While the queue is full, a command whose address matches a waiting entry is still accepted (`pushReady` is 1) and merges per R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pushValid | input | 1 | Writeback command offered |
| pushReady | output | 1 | Command is accepted this cycle when pushValid is high |
| pushAddr | input | ADDR_W | Page table entry address |
| pushRef | input | VEC_W | Reference vector of the evicted entry |
| pushVal | input | VEC_W | Valid vector of the evicted entry |
| memRdEn | output | 1 | Page table read strobe |
| memWrEn | output | 1 | Page table write strobe |
| memAddr | output | ADDR_W | Address for read and write |
| memRdData | input | PTE_W | Entry read data, one cycle after memRdEn |
| memWrData | output | PTE_W | Merged entry to write |
| drained | output | 1 | Queue empty and no writeback in flight |

## Verification
The bench sweeps every table address with a distinct reference pattern, including an all-zero valid vector. A design that overwrote instead of ORing, shifted a field, or disturbed a translation bit would leave a wrong table word. A burst of repeated addresses issued while the drain is busy targets merging: a design that failed to coalesce would issue an extra write, and one that replaced the reference vector would lose earlier bits. A fill faster than the drain forces the full condition. There, a design with no backpressure would either overwrite a slot or write a dropped address, and a design that refused a matching address while full would fail the merge check. A separate ordered burst catches swapped drain order.

// File: rtl/fpWbPkg.sv
package fpWbPkg;
  // strobes from control to datapath, one action each
  typedef struct packed {
    logic pushNew;    // write command into free tail slot
    logic pushMerge;  // fold command into matching waiting slot
    logic popHead;    // take head slot for writeback
  } wbStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_WRITE = 2'd2
  } wbState_t;
endpackage

// File: rtl/fpWbCtrl.sv
module fpWbCtrl
  import fpWbPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      pushValid,
  input  logic      queueEmpty,
  input  logic      queueFull,
  input  logic      addrHit,
  output logic      headLeaving,
  output logic      pushReady,
  output wbStrobe_t strb,
  output logic      memRdEn,
  output logic      memWrEn,
  output logic      drained
);
  wbState_t state, stateNext;

  always_comb begin
    headLeaving    = (state == ST_IDLE) && !queueEmpty;
    pushReady      = !queueFull || addrHit;
    strb.popHead   = headLeaving;
    strb.pushMerge = pushValid && addrHit;
    strb.pushNew   = pushValid && !addrHit && !queueFull;
    memRdEn        = (state == ST_READ);
    memWrEn        = (state == ST_WRITE);
    drained        = queueEmpty && (state == ST_IDLE);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (!queueEmpty) stateNext = ST_READ;
      ST_READ:  stateNext = ST_WRITE;
      ST_WRITE: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  AST_DRAINED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    drained |-> (!memRdEn && !memWrEn)); // R9
  AST_POP_THEN_READ: assert property (@(posedge clk) disable iff (!rstN)
    strb.popHead |=> memRdEn); // R8
  AST_REJECT_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && !pushReady) |-> (!strb.pushNew && !strb.pushMerge)); // R7
endmodule

// File: rtl/fpWbStore.sv
module fpWbStore
  import fpWbPkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DEPTH   = 4,
  parameter int VEC_W   = 8,
  parameter int PTE_W   = 64,
  parameter int REF_LSB = 56,
  parameter int VAL_LSB = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  wbStrobe_t         strb,
  input  logic              headLeaving,
  input  logic [ADDR_W-1:0] pushAddr,
  input  logic [VEC_W-1:0]  pushRef,
  input  logic [VEC_W-1:0]  pushVal,
  input  logic [PTE_W-1:0]  memRdData,
  output logic              queueEmpty,
  output logic              queueFull,
  output logic              addrHit,
  output logic [ADDR_W-1:0] memAddr,
  output logic [PTE_W-1:0]  memWrData
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [ADDR_W-1:0] entAddr [DEPTH];
  logic [VEC_W-1:0]  entRef  [DEPTH];
  logic [VEC_W-1:0]  entVal  [DEPTH];
  logic [DEPTH-1:0]  busy;
  logic [DEPTH-1:0]  matchVec;
  logic [PTR_W-1:0]  rdPtr, wrPtr, hitIdx;
  logic [CNT_W-1:0]  count;

  logic [ADDR_W-1:0] capAddr;
  logic [VEC_W-1:0]  capRef;
  logic [VEC_W-1:0]  capVal;

  // one address comparator per slot; the slot leaving this cycle is excluded
  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_match
      assign matchVec[gi] = busy[gi] && (entAddr[gi] == pushAddr) &&
                            !(headLeaving && (rdPtr == PTR_W'(gi)));
    end
  endgenerate

  always_comb begin
    hitIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (matchVec[i]) hitIdx = PTR_W'(i);
    end
  end

  assign addrHit    = |matchVec;
  assign queueEmpty = (count == '0);
  assign queueFull  = (count == FULL_CNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy  <= '0;
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        entAddr[i] <= '0;
        entRef[i]  <= '0;
        entVal[i]  <= '0;
      end
      capAddr <= '0;
      capRef  <= '0;
      capVal  <= '0;
    end else begin
      if (strb.pushNew) begin
        entAddr[wrPtr] <= pushAddr;
        entRef[wrPtr]  <= pushRef;
        entVal[wrPtr]  <= pushVal;
        busy[wrPtr]    <= 1'b1;
        wrPtr          <= (wrPtr == LAST_SLOT) ? '0 : wrPtr + 1'b1;
      end
      if (strb.pushMerge) begin
        entRef[hitIdx] <= entRef[hitIdx] | pushRef;
        entVal[hitIdx] <= pushVal;
      end
      if (strb.popHead) begin
        capAddr     <= entAddr[rdPtr];
        capRef      <= entRef[rdPtr];
        capVal      <= entVal[rdPtr];
        busy[rdPtr] <= 1'b0;
        rdPtr       <= (rdPtr == LAST_SLOT) ? '0 : rdPtr + 1'b1;
      end
      case ({strb.pushNew, strb.popHead})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // merge of captured vectors into the entry just read
  always_comb begin
    memWrData = memRdData;
    memWrData[REF_LSB +: VEC_W] = memRdData[REF_LSB +: VEC_W] | capRef;
    memWrData[VAL_LSB +: VEC_W] = capVal;
  end
  assign memAddr = capAddr;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT); // R7
  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec)); // R6
  AST_POP_OCCUPIED: assert property (@(posedge clk) disable iff (!rstN)
    strb.popHead |-> busy[rdPtr]); // R5
  AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    $countones(busy) == int'(count)); // R6
endmodule

// File: rtl/fpWbQueue.sv
module fpWbQueue
  import fpWbPkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DEPTH   = 4,
  parameter int VEC_W   = 8,
  parameter int PTE_W   = 64,
  parameter int REF_LSB = 56,
  parameter int VAL_LSB = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  output logic              pushReady,
  input  logic [ADDR_W-1:0] pushAddr,
  input  logic [VEC_W-1:0]  pushRef,
  input  logic [VEC_W-1:0]  pushVal,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [PTE_W-1:0]  memRdData,
  output logic [PTE_W-1:0]  memWrData,
  output logic              drained
);
  wbStrobe_t strb;
  logic queueEmpty, queueFull, addrHit, headLeaving;

  fpWbCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .pushValid(pushValid),
    .queueEmpty(queueEmpty), .queueFull(queueFull), .addrHit(addrHit),
    .headLeaving(headLeaving), .pushReady(pushReady), .strb(strb),
    .memRdEn(memRdEn), .memWrEn(memWrEn), .drained(drained)
  );

  fpWbStore #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .VEC_W(VEC_W), .PTE_W(PTE_W),
    .REF_LSB(REF_LSB), .VAL_LSB(VAL_LSB)
  ) i_store (
    .clk(clk), .rstN(rstN), .strb(strb), .headLeaving(headLeaving),
    .pushAddr(pushAddr), .pushRef(pushRef), .pushVal(pushVal),
    .memRdData(memRdData), .queueEmpty(queueEmpty), .queueFull(queueFull),
    .addrHit(addrHit), .memAddr(memAddr), .memWrData(memWrData)
  );

  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> (memWrEn && $stable(memAddr))); // R8
  AST_KEEP_XLATE: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (memWrData[VAL_LSB-1:0] == memRdData[VAL_LSB-1:0])); // R2
  AST_REF_GROWS: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> ((memWrData[REF_LSB +: VEC_W] & memRdData[REF_LSB +: VEC_W])
                 == memRdData[REF_LSB +: VEC_W])); // R3
endmodule

// File: tb/test_fpWbQueue.sv
module test_fpWbQueue;
  localparam int AW = 12;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushValid = 1'b0;
  logic pushReady;
  logic [AW-1:0] pushAddr = '0;
  logic [7:0] pushRef = '0, pushVal = '0;
  logic memRdEn, memWrEn, drained;
  logic [AW-1:0] memAddr;
  logic [63:0] memRdData, memWrData;

  int total = 0, bad = 0;
  logic [63:0] pt [16];
  logic [63:0] expMem [16];
  logic [63:0] initMem [16];
  logic [3:0] wrLog [256];
  int wrCnt = 0;
  logic prevRd = 1'b0;
  logic [AW-1:0] prevAddr = '0;

  always #10 clk = ~clk;

  fpWbQueue i_fpWbQueue (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushReady(pushReady),
    .pushAddr(pushAddr), .pushRef(pushRef), .pushVal(pushVal),
    .memRdEn(memRdEn), .memWrEn(memWrEn), .memAddr(memAddr),
    .memRdData(memRdData), .memWrData(memWrData), .drained(drained)
  );

  // page table model: one-cycle read latency
  always @(posedge clk) begin
    if (memRdEn) memRdData <= pt[memAddr[3:0]];
    if (memWrEn) begin
      pt[memAddr[3:0]] <= memWrData;
      wrLog[wrCnt[7:0]] <= memAddr[3:0];
      wrCnt <= wrCnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R8: write follows read to the same address
  always @(negedge clk) begin
    if (rstN && memWrEn) chk(prevRd && (prevAddr == memAddr), "R8", {52'd0, memAddr}, {52'd0, prevAddr});
    prevRd = memRdEn;
    prevAddr = memAddr;
  end

  task automatic push(input logic [3:0] a, input logic [7:0] r, input logic [7:0] v, output bit acc);
    @(negedge clk);
    pushValid = 1'b1; pushAddr = AW'(a); pushRef = r; pushVal = v;
    #1;
    acc = pushReady;
    if (acc) begin
      expMem[a][63:56] = expMem[a][63:56] | r;
      expMem[a][55:48] = v;
    end
    @(posedge clk);
    #1 pushValid = 1'b0;
  endtask

  task automatic waitDrained();
    int n = 0;
    @(negedge clk);
    while (!drained && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 2000) chk(1'b0, "R9 drain timeout", 64'(n), 64'd0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit acc;
    int base;
    bit sawReject, prevRej;
    logic [3:0] lastAcc, fresh;
    for (int i = 0; i < 16; i++) begin
      initMem[i] = {8'(i * 37), 8'(8'h5A ^ i), 48'h0000_1234_5600 + 48'(i * 65537)};
      pt[i] = initMem[i];
      expMem[i] = initMem[i];
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(drained === 1'b1, "R1 drained", 64'(drained), 64'd1);
    chk(pushReady === 1'b1, "R1 pushReady", 64'(pushReady), 64'd1);
    chk(!memRdEn && !memWrEn, "R1 strobes", {62'd0, memRdEn, memWrEn}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // sweep every address: layout R2, OR merge R3, replace/clear R4, drained R9
    for (int a = 0; a < 16; a++) begin
      push(4'(a), 8'(a * 29 + 3), (a == 5) ? 8'h00 : 8'(a * 11 + 1), acc);
      chk(acc, "R7 accept when empty", 64'(acc), 64'd1);
      @(negedge clk);
      chk(!drained, "R9 busy after push", 64'(drained), 64'd0);
      waitDrained();
      chk(pt[a] === expMem[a], "R3 merged entry", pt[a], expMem[a]);
      chk(pt[a][47:0] === initMem[a][47:0], "R2 translation kept", pt[a], initMem[a]);
      chk(pt[a][55:48] === ((a == 5) ? 8'h00 : 8'(a * 11 + 1)), "R4 valid field",
          64'(pt[a][55:48]), 64'((a == 5) ? 8'h00 : 8'(a * 11 + 1)));
    end

    // R5 order for distinct addresses
    base = wrCnt;
    for (int k = 0; k < 4; k++) push(4'(9 - 2 * k), 8'(1 << k), 8'(k), acc);
    waitDrained();
    chk(wrCnt - base == 4, "R5 write count", 64'(wrCnt - base), 64'd4);
    for (int k = 0; k < 4; k++)
      chk(wrLog[8'(base + k)] == 4'(9 - 2 * k), "R5 order", 64'(wrLog[8'(base + k)]), 64'(9 - 2 * k));

    // R6 coalescing while drain busy
    base = wrCnt;
    push(4'd1, 8'h01, 8'h11, acc);
    push(4'd2, 8'h02, 8'h22, acc);
    push(4'd3, 8'h10, 8'h31, acc);
    push(4'd3, 8'h20, 8'h32, acc);
    push(4'd3, 8'h80, 8'h33, acc);
    waitDrained();
    chk(wrCnt - base == 3, "R6 merged write count", 64'(wrCnt - base), 64'd3);
    chk(pt[3] === expMem[3], "R6 merged vectors", pt[3], expMem[3]);

    // R7 backpressure, R10 merge while full
    sawReject = 0; prevRej = 0; lastAcc = 4'd4; fresh = 4'd4;
    for (int k = 0; k < 11; k++) begin
      if (prevRej) begin
        push(lastAcc, 8'(8'h40 >> (k % 4)), 8'(k + 100), acc);
        chk(acc, "R10 merge accepted when full", 64'(acc), 64'd1);
        prevRej = 0;
      end else begin
        push(fresh, 8'(k * 7 + 1), 8'(k + 50), acc);
        if (acc) lastAcc = fresh;
        else begin
          sawReject = 1;
          prevRej = 1;
        end
        fresh = fresh + 4'd1;
      end
    end
    chk(sawReject, "R7 backpressure seen", 64'(sawReject), 64'd1);
    waitDrained();
    for (int i = 0; i < 16; i++)
      chk(pt[i] === expMem[i], "R7 table after fill", pt[i], expMem[i]);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule